// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block sits between a CPU with a 16-bit address bus and a cartridge ROM array. Writes that land in the read-only region (below 0x8000) never reach memory; they are decoded as control writes that load a 5-bit switchable-bank register and a 1-bit mode register. Reads in the read-only region are translated into a 19-bit physical ROM address. The lower 16 KB window (0x0000-0x3FFF) always maps to the first 16 KB of the ROM. The upper window (0x4000-0x7FFF) is remapped through the latched bank number.

A two-bit cartridge-type input selects the behaviour. A plain cartridge ignores every control write. A banked cartridge decodes control writes by address range. Any other type value raises a one-cycle error pulse when a control write arrives. The physical address comes out of a register one cycle after the read request, together with a valid strobe.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset, the bank register reads 1, the mode bit reads 0, and both `err` and `rom_vld` are low.
- R2: A read at address A with A[15:14]=00 drives `rom_vld` high on the next cycle, with `rom_addr` = A zero-extended to 19 bits.
- R3: A read at address A with A[15:14]=01 drives `rom_vld` high on the next cycle, with `rom_addr` = bank×0x4000 + (A − 0x4000), i.e. {bank, A[13:0]}. The bank used is the value held in the cycle of the read.
- R4: With cart type 2'b01 (banked), a write to 0x2000-0x3FFF (A[15:13]=001) loads the bank register from data bits [4:0]. Data bits [7:5] are dropped.
- R5: With cart type 2'b01, a write to 0x6000-0x7FFF (A[15:13]=011) loads the mode bit from data bit 0.
- R6: A bank register value of 0 maps the upper window as bank 1.
- R7: With cart type 2'b00 (plain), writes below 0x8000 change neither the bank nor the mode register.
- R8: With cart type 2'b01, writes to 0x0000-0x1FFF, 0x4000-0x5FFF or at or above 0x8000 leave both registers unchanged.
- R9: With cart type 2'b10 or 2'b11, a write below 0x8000 raises `err` for exactly the following cycle and leaves both registers unchanged. A write at or above 0x8000 does not raise `err`.
- R10: A read at or above 0x8000 does not raise `rom_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cart_type | input | 2 | 00 plain, 01 banked, 10/11 unsupported |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rom_addr | output | 19 | Registered physical ROM address |
| rom_vld | output | 1 | `rom_addr` holds a translated read |
| bank_q | output | 5 | Current switchable-bank register |
| mode_q | output | 1 | Current mode bit |
| err | output | 1 | One-cycle pulse after a control write on an unsupported type |

## Verification
A corrupted bank register shows on `bank_q` in the cycle after the bad write. It also shows in the upper five bits of `rom_addr` on the first upper-window read after that. A fault in the decode, such as the wrong address nibble or a missing type gate, moves `bank_q` or `mode_q` one cycle after a write that should have been ignored. A fault in the translation shows in the very next cycle as a mismatched `rom_addr` against the scoreboard, or as a `rom_vld` with no queued read. A bank-zero remap fault only appears when an upper-window read follows a write of 0.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_ADDR_W = 16;
  localparam int CPU_DATA_W = 8;
  localparam int SEL_W      = 5;

  typedef enum logic [1:0] {
    CART_PLAIN  = 2'b00,
    CART_BANKED = 2'b01
  } cart_kind_e;

  // upper three address bits that pick the control-write target
  localparam logic [2:0] RGN_BANK = 3'b001;
  localparam logic [2:0] RGN_MODE = 3'b011;
endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
  import cbc_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] cart_type,
  input  logic [2:0] rgn,
  output logic       ld_bank,
  output logic       ld_mode,
  output logic       bad_wr
);
  logic in_rom;
  logic banked;
  logic plain;

  always_comb begin
    in_rom  = ~rgn[2];
    banked  = (cart_type == CART_BANKED);
    plain   = (cart_type == CART_PLAIN);
    ld_bank = wr_en & in_rom & banked & (rgn == RGN_BANK);
    ld_mode = wr_en & in_rom & banked & (rgn == RGN_MODE);
    bad_wr  = wr_en & in_rom & ~banked & ~plain;
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs #(
  parameter int BANK_W     = 5,
  parameter int RESET_BANK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_bank,
  input  logic              ld_mode,
  input  logic              bad_wr,
  input  logic [BANK_W-1:0] bank_d,
  input  logic              mode_d,
  output logic [BANK_W-1:0] bank_q,
  output logic              mode_q,
  output logic              err_q
);
  localparam logic [BANK_W-1:0] BANK_INIT = BANK_W'(RESET_BANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= BANK_INIT;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ld_bank) bank_q <= bank_d;
      if (ld_mode) mode_q <= mode_d;
      err_q <= bad_wr;
    end
  end
endmodule

// File: rtl/cbc_map.sv
module cbc_map #(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 5,
  parameter bit ZERO_AS_ONE = 1'b1,
  localparam int WIN_W      = ADDR_W - 2,
  localparam int PHYS_W     = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [PHYS_W-1:0] rom_addr,
  output logic              rom_vld
);
  logic [BANK_W-1:0] eff_bank;
  logic [BANK_W-1:0] sel_bank;
  logic [1:0]        win;

  generate
    if (ZERO_AS_ONE) begin : g_remap0
      always_comb eff_bank = (bank == '0) ? BANK_W'(1) : bank;
    end else begin : g_plain
      always_comb eff_bank = bank;
    end
  endgenerate

  always_comb begin
    win      = addr[ADDR_W-1 -: 2];
    sel_bank = win[0] ? eff_bank : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_vld  <= 1'b0;
      rom_addr <= '0;
    end else begin
      rom_vld <= rd_en & ~win[1];
      if (rd_en & ~win[1]) rom_addr <= {sel_bank, addr[WIN_W-1:0]};
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W     = CPU_ADDR_W,
  parameter int DATA_W     = CPU_DATA_W,
  parameter int BANK_W     = SEL_W,
  localparam int PHYS_W    = BANK_W + ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cart_type,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PHYS_W-1:0] rom_addr,
  output logic              rom_vld,
  output logic [BANK_W-1:0] bank_q,
  output logic              mode_q,
  output logic              err
);
  logic ld_bank, ld_mode, bad_wr;
  logic unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:BANK_W];

  cbc_wr_decode u_dec (
    .wr_en     (wr_en),
    .cart_type (cart_type),
    .rgn       (addr[ADDR_W-1 -: 3]),
    .ld_bank   (ld_bank),
    .ld_mode   (ld_mode),
    .bad_wr    (bad_wr)
  );

  cbc_regs #(.BANK_W(BANK_W), .RESET_BANK(1)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ld_bank (ld_bank),
    .ld_mode (ld_mode),
    .bad_wr  (bad_wr),
    .bank_d  (wdata[BANK_W-1:0]),
    .mode_d  (wdata[0]),
    .bank_q  (bank_q),
    .mode_q  (mode_q),
    .err_q   (err)
  );

  cbc_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .ZERO_AS_ONE(1'b1)) u_map (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .bank     (bank_q),
    .rom_addr (rom_addr),
    .rom_vld  (rom_vld)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cart_type,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic [18:0] rom_addr,
  input logic        rom_vld,
  input logic [4:0]  bank_q,
  input logic        mode_q,
  input logic        err
);
  logic unused_ck;
  assign unused_ck = ^wdata[7:5];

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_q == 5'd1 && !mode_q && !err && !rom_vld));

  p_fixed_window_r2: assert property (@(posedge clk) disable iff (rst)
    (rom_vld && $past(addr[15:14]) == 2'b00) |-> rom_addr == {5'd0, $past(addr[13:0])});

  p_switch_window_r3: assert property (@(posedge clk) disable iff (rst)
    (rom_vld && $past(addr[15:14]) == 2'b01) |->
      (rom_addr[13:0] == $past(addr[13:0]) && rom_addr[18:14] != 5'd0));

  p_bank_load_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(cart_type) == 2'b01 && $past(addr[15:13]) == 3'b001)
      |-> bank_q == $past(wdata[4:0]));

  p_mode_load_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(cart_type) == 2'b01 && $past(addr[15:13]) == 3'b011)
      |-> mode_q == $past(wdata[0]));

  p_plain_ignores_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(cart_type) == 2'b00) |-> ($stable(bank_q) && $stable(mode_q)));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(wr_en) && $past(cart_type[1]) && !$past(addr[15])));

  p_no_hi_read_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr[15])) |-> !rom_vld);

  p_read_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    rom_vld |-> $past(rd_en));
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cart_type (cart_type),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rom_addr  (rom_addr),
  .rom_vld   (rom_vld),
  .bank_q    (bank_q),
  .mode_q    (mode_q),
  .err       (err)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cart_type = 2'b01;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [18:0] rom_addr;
  logic        rom_vld;
  logic [4:0]  bank_q;
  logic        mode_q;
  logic        err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [4:0]  m_bank = 5'd1;
  logic [18:0] exp_q[$];

  always #5 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst(rst), .cart_type(cart_type), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rom_addr(rom_addr), .rom_vld(rom_vld),
    .bank_q(bank_q), .mode_q(mode_q), .err(err)
  );

  function automatic logic [18:0] phys(input logic [15:0] a, input logic [4:0] b);
    logic [4:0] be;
    be = (b == 5'd0) ? 5'd1 : b;
    return a[14] ? {be, a[13:0]} : {5'd0, a[13:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop scoreboard on every valid translation
  always @(negedge clk) begin
    if (!rst && rom_vld) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rom_vld", 32'(rom_addr), 32'h7FFFF);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk("R2/R3 rom_addr", 32'(rom_addr), 32'(e));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    if (cart_type == 2'b01 && a[15:13] == 3'b001) m_bank = d[4:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    if (!a[15]) exp_q.push_back(phys(a, m_bank));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 bank after reset", 32'(bank_q), 32'd1);
    chk("R1 mode after reset", 32'(mode_q), 32'd0);
    chk("R1 err after reset", 32'(err), 32'd0);
    chk("R1 vld after reset", 32'(rom_vld), 32'd0);

    // R2 fixed window
    rd(16'h0000); rd(16'h3FFF); rd(16'h1234);
    // R3 switchable window with reset bank
    rd(16'h4000); rd(16'h7FFF);

    // R4 bank load
    wr(16'h2000, 8'h05);
    chk("R4 bank load 5", 32'(bank_q), 32'd5);
    rd(16'h4ABC);
    wr(16'h3FFF, 8'hFF);
    chk("R4 bank drops bits 7:5", 32'(bank_q), 32'd31);
    // back-to-back reads through the pipeline
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr = 16'h3000 + 16'(i) * 16'h0A01; rd_en = 1'b1;
      exp_q.push_back(phys(addr, m_bank));
    end
    @(negedge clk); rd_en = 1'b0;

    // R6 bank zero
    wr(16'h2100, 8'h00);
    chk("R6 bank reg holds 0", 32'(bank_q), 32'd0);
    rd(16'h4000); rd(16'h5555);

    // R5 mode bit
    wr(16'h6000, 8'h03);
    chk("R5 mode set", 32'(mode_q), 32'd1);
    wr(16'h7FFF, 8'hFE);
    chk("R5 mode clear", 32'(mode_q), 32'd0);

    // R8 other ranges ignored on banked type
    wr(16'h2000, 8'h09);
    wr(16'h0000, 8'h0A);
    chk("R8 write 0x0000 ignored", 32'(bank_q), 32'd9);
    wr(16'h5000, 8'h0B);
    chk("R8 write 0x5000 ignored", 32'(bank_q), 32'd9);
    wr(16'hA000, 8'h0C);
    chk("R8 write 0xA000 ignored", 32'(bank_q), 32'd9);
    wr(16'h1FFF, 8'h01);
    chk("R8 mode untouched", 32'(mode_q), 32'd0);
    rd(16'h6001);

    // R7 plain cartridge
    cart_type = 2'b00;
    wr(16'h2000, 8'h07);
    chk("R7 plain bank unchanged", 32'(bank_q), 32'd9);
    wr(16'h6000, 8'h01);
    chk("R7 plain mode unchanged", 32'(mode_q), 32'd0);
    chk("R7 plain no err", 32'(err), 32'd0);

    // R9 unsupported type
    cart_type = 2'b10;
    wr(16'h2000, 8'h03);
    chk("R9 err raised", 32'(err), 32'd1);
    chk("R9 bank unchanged", 32'(bank_q), 32'd9);
    @(negedge clk);
    chk("R9 err one cycle", 32'(err), 32'd0);
    cart_type = 2'b11;
    wr(16'h8000, 8'h03);
    chk("R9 no err above 0x8000", 32'(err), 32'd0);
    wr(16'h7000, 8'h01);
    chk("R9 err type 11", 32'(err), 32'd1);
    chk("R9 mode unchanged", 32'(mode_q), 32'd0);

    // R10 reads above ROM space
    cart_type = 2'b01;
    @(negedge clk); addr = 16'h8000; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 no vld at 0x8000", 32'(rom_vld), 32'd0);
    @(negedge clk); addr = 16'hFFFF; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 no vld at 0xFFFF", 32'(rom_vld), 32'd0);

    repeat (3) @(negedge clk);
    chk("R2/R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule